// File: doc/BRIEF.md
# Configurable Pipelined Multiplier Element

A hard-arithmetic style multiplier cell that forms the full-width product of an A_W-bit operand and a B_W-bit operand, producing an (A_W+B_W)-bit result. It only multiplies: there is no adder, no accumulator and no feedback of earlier results. A single control input picks, per operand pair, whether both operands are read as two's-complement or as unsigned numbers.

Three register stages sit along the datapath and each one is kept or bypassed by its own parameter. The stages are an operand capture stage, a stage right after the multiplier, and a final result stage, so latency can be set anywhere from zero to three cycles. Each operand capture stage can take its data from the normal data port or from a cascade input, again chosen by a parameter. The captured operand is always shown on a cascade output, so a row of cells can be wired head to tail into a tapped delay line for filter structures. All stages share one clock, one clock enable and one synchronous reset.

Top module: `cfg_mult_cell`

## Requirements
- R1: `product` equals the arithmetic product of the two operands reduced to A_W+B_W bits, and each result depends only on its own operand pair, never on earlier results.
- R2: With `is_signed`=1 both operands are read as two's-complement (most significant bit is the sign); with `is_signed`=0 both are read as unsigned.
- R3: Parameters IN_REG_EN, PIPE_REG_EN and OUT_REG_EN (each 0 or 1) keep or bypass their stage independently; latency in cycles equals their sum, and with all three 0 the product follows the inputs with no clock edge.
- R4: While `ce` is 0 and `srst` is 0, every kept register holds, so `product` and the cascade outputs do not change whatever the inputs do.
- R5: `srst`=1 at a rising clock edge clears every kept register to zero, whatever `ce` is; with at least one stage kept `product` then reads 0 and kept cascade outputs read 0.
- R6: With the operand capture stage kept, `a_chain_out`/`b_chain_out` show the operand captured from its selected source at the previous enabled edge; with it bypassed they show the selected source directly.
- R7: Parameter A_SRC_CHAIN (B_SRC_CHAIN) chooses the A (B) operand source: 0 takes the data port `a_in` (`b_in`), 1 takes the cascade input `a_chain_in` (`b_chain_in`); the unselected port has no effect on the product.
- R8: `is_signed` is captured in the operand capture stage together with the operands, so every product uses the mode presented in the same cycle as its operands, even when the mode changes every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all register stages |
| ce | input | 1 | Clock enable, active high, for all stages |
| srst | input | 1 | Synchronous reset, active high |
| a_in | input | A_W | Operand A data port |
| b_in | input | B_W | Operand B data port |
| a_chain_in | input | A_W | Operand A cascade input |
| b_chain_in | input | B_W | Operand B cascade input |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| a_chain_out | output | A_W | Operand A cascade output |
| b_chain_out | output | B_W | Operand B cascade output |
| product | output | A_W+B_W | Product result |

## Verification
The bench sweeps every 4-bit by 4-bit operand pair in both modes through three differently configured cells at once, toggling the sign mode on every vector, so a cell that registered the mode one stage late, or sign-extended only one operand, gives wrong products at the most negative operand values. Latency is checked by streaming one vector per cycle and comparing at exactly the configured depth, which catches a stage that was kept when it should be bypassed or the reverse. The unselected source of each operand carries different data than the selected one, so a wrong source mux shows up as a miscompare, and the cascade outputs are compared one cycle after capture. A clock enable pause with moving inputs and a reset asserted while the enable is low target a design that lets a stage slip or that gates reset with the enable.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

   // Number of kept register stages, which is also the latency in cycles.
   function automatic int stage_count(input int in_en, input int pipe_en, input int out_en);
      return in_en + pipe_en + out_en;
   endfunction

   function automatic bit is_flag(input int v);
      return (v == 0) || (v == 1);
   endfunction

endpackage

// File: rtl/cmul_stage_reg.sv
module cmul_stage_reg #(
   parameter int W  = 8,
   parameter int EN = 1
) (
   input  logic         clk,
   input  logic         ce,
   input  logic         srst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("cmul_stage_reg: W must be at least 1");
   end

   if (EN != 0) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
         if (srst)
            q_r <= '0;
         else if (ce)
            q_r <= d;
      end
      assign q = q_r;
   end else begin : g_bypass
      assign q = d;
   end

endmodule

// File: rtl/cmul_opnd_stage.sv
module cmul_opnd_stage #(
   parameter int W         = 8,
   parameter int USE_CHAIN = 0,
   parameter int REG_EN    = 1
) (
   input  logic         clk,
   input  logic         ce,
   input  logic         srst,
   input  logic [W-1:0] port_d,
   input  logic [W-1:0] chain_d,
   output logic [W-1:0] q
);

   logic [W-1:0] src;

   if (USE_CHAIN != 0) begin : g_from_chain
      assign src = chain_d;
   end else begin : g_from_port
      assign src = port_d;
   end

   cmul_stage_reg #(
      .W  (W),
      .EN (REG_EN)
   ) u_cap (
      .clk  (clk),
      .ce   (ce),
      .srst (srst),
      .d    (src),
      .q    (q)
   );

endmodule

// File: rtl/cmul_core.sv
module cmul_core #(
   parameter int A_W = 9,
   parameter int B_W = 9
) (
   input  logic [A_W-1:0]     a,
   input  logic [B_W-1:0]     b,
   input  logic               is_signed,
   output logic [A_W+B_W-1:0] p
);

   localparam int P_W = A_W + B_W;

   logic [P_W-1:0] a_ext;
   logic [P_W-1:0] b_ext;
   logic           a_fill;
   logic           b_fill;

   // Widening both operands to the full product width makes the
   // truncated unsigned product equal the two's-complement product.
   assign a_fill = is_signed & a[A_W-1];
   assign b_fill = is_signed & b[B_W-1];
   assign a_ext  = {{B_W{a_fill}}, a};
   assign b_ext  = {{A_W{b_fill}}, b};
   assign p      = a_ext * b_ext;

endmodule

// File: rtl/cfg_mult_cell.sv
module cfg_mult_cell
   import cmul_pkg::*;
#(
   parameter int A_W         = 9,
   parameter int B_W         = 9,
   parameter int IN_REG_EN   = 1,
   parameter int PIPE_REG_EN = 1,
   parameter int OUT_REG_EN  = 1,
   parameter int A_SRC_CHAIN = 0,
   parameter int B_SRC_CHAIN = 0
) (
   input  logic               clk,
   input  logic               ce,
   input  logic               srst,
   input  logic [A_W-1:0]     a_in,
   input  logic [B_W-1:0]     b_in,
   input  logic [A_W-1:0]     a_chain_in,
   input  logic [B_W-1:0]     b_chain_in,
   input  logic               is_signed,
   output logic [A_W-1:0]     a_chain_out,
   output logic [B_W-1:0]     b_chain_out,
   output logic [A_W+B_W-1:0] product
);

   localparam int P_W     = A_W + B_W;
   localparam int LATENCY = stage_count(IN_REG_EN, PIPE_REG_EN, OUT_REG_EN);

   if (A_W < 2 || B_W < 2) begin : g_bad_width
      $error("cfg_mult_cell: operand widths must be at least 2");
   end
   if (!is_flag(IN_REG_EN) || !is_flag(PIPE_REG_EN) || !is_flag(OUT_REG_EN)) begin : g_bad_stage
      $error("cfg_mult_cell: stage enables must be 0 or 1");
   end
   if (!is_flag(A_SRC_CHAIN) || !is_flag(B_SRC_CHAIN)) begin : g_bad_src
      $error("cfg_mult_cell: source selects must be 0 or 1");
   end
   if (LATENCY > 3) begin : g_bad_lat
      $error("cfg_mult_cell: latency out of range");
   end

   logic [A_W-1:0] a_cap;
   logic [B_W-1:0] b_cap;
   logic           sgn_cap;
   logic [P_W-1:0] prod_raw;
   logic [P_W-1:0] prod_pipe;

   cmul_opnd_stage #(
      .W         (A_W),
      .USE_CHAIN (A_SRC_CHAIN),
      .REG_EN    (IN_REG_EN)
   ) u_opnd_a (
      .clk     (clk),
      .ce      (ce),
      .srst    (srst),
      .port_d  (a_in),
      .chain_d (a_chain_in),
      .q       (a_cap)
   );

   cmul_opnd_stage #(
      .W         (B_W),
      .USE_CHAIN (B_SRC_CHAIN),
      .REG_EN    (IN_REG_EN)
   ) u_opnd_b (
      .clk     (clk),
      .ce      (ce),
      .srst    (srst),
      .port_d  (b_in),
      .chain_d (b_chain_in),
      .q       (b_cap)
   );

   // The mode bit travels with the operands through the capture stage.
   cmul_stage_reg #(
      .W  (1),
      .EN (IN_REG_EN)
   ) u_sgn_cap (
      .clk  (clk),
      .ce   (ce),
      .srst (srst),
      .d    (is_signed),
      .q    (sgn_cap)
   );

   cmul_core #(
      .A_W (A_W),
      .B_W (B_W)
   ) u_core (
      .a         (a_cap),
      .b         (b_cap),
      .is_signed (sgn_cap),
      .p         (prod_raw)
   );

   cmul_stage_reg #(
      .W  (P_W),
      .EN (PIPE_REG_EN)
   ) u_pipe (
      .clk  (clk),
      .ce   (ce),
      .srst (srst),
      .d    (prod_raw),
      .q    (prod_pipe)
   );

   cmul_stage_reg #(
      .W  (P_W),
      .EN (OUT_REG_EN)
   ) u_out (
      .clk  (clk),
      .ce   (ce),
      .srst (srst),
      .d    (prod_pipe),
      .q    (product)
   );

   assign a_chain_out = a_cap;
   assign b_chain_out = b_cap;

endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
   parameter int A_W         = 9,
   parameter int B_W         = 9,
   parameter int IN_REG_EN   = 1,
   parameter int PIPE_REG_EN = 1,
   parameter int OUT_REG_EN  = 1,
   parameter int A_SRC_CHAIN = 0,
   parameter int B_SRC_CHAIN = 0
) (
   input logic               clk,
   input logic               ce,
   input logic               srst,
   input logic [A_W-1:0]     a_in,
   input logic [B_W-1:0]     b_in,
   input logic [A_W-1:0]     a_chain_in,
   input logic [B_W-1:0]     b_chain_in,
   input logic [A_W-1:0]     a_chain_out,
   input logic [B_W-1:0]     b_chain_out,
   input logic [A_W+B_W-1:0] product
);

   localparam int LAT = IN_REG_EN + PIPE_REG_EN + OUT_REG_EN;

   logic [A_W-1:0] a_src;
   logic [B_W-1:0] b_src;
   logic           rst_seen = 1'b0;

   assign a_src = (A_SRC_CHAIN != 0) ? a_chain_in : a_in;
   assign b_src = (B_SRC_CHAIN != 0) ? b_chain_in : b_in;

   always_ff @(posedge clk) rst_seen <= srst;

   if (LAT > 0) begin : g_seq
      // R4: a paused cell keeps its result
      p_hold_r4: assert property (@(posedge clk) disable iff (srst)
         !ce |=> $stable(product))
         else $error("p_hold_r4: product moved while clock enable low");

      // R5: reset leaves a zero result, whatever the enable did
      always @(posedge clk) begin
         if (rst_seen) begin
            p_reset_zero_r5: assert (product == '0)
               else $error("p_reset_zero_r5: product not cleared by reset");
         end
      end
   end

   if (IN_REG_EN != 0) begin : g_cap
      // R6: cascade outputs carry the operand captured at the last enabled edge
      p_chain_a_r6: assert property (@(posedge clk) disable iff (srst)
         ce |=> (a_chain_out == $past(a_src)))
         else $error("p_chain_a_r6: A cascade output mismatch");

      p_chain_b_r6: assert property (@(posedge clk) disable iff (srst)
         ce |=> (b_chain_out == $past(b_src)))
         else $error("p_chain_b_r6: B cascade output mismatch");

      // R4: cascade outputs also hold while paused
      p_chain_hold_r4: assert property (@(posedge clk) disable iff (srst)
         !ce |=> ($stable(a_chain_out) && $stable(b_chain_out)))
         else $error("p_chain_hold_r4: cascade output moved while paused");
   end

endmodule

bind cfg_mult_cell cmul_checker #(
   .A_W         (A_W),
   .B_W         (B_W),
   .IN_REG_EN   (IN_REG_EN),
   .PIPE_REG_EN (PIPE_REG_EN),
   .OUT_REG_EN  (OUT_REG_EN),
   .A_SRC_CHAIN (A_SRC_CHAIN),
   .B_SRC_CHAIN (B_SRC_CHAIN)
) u_chk (
   .clk         (clk),
   .ce          (ce),
   .srst        (srst),
   .a_in        (a_in),
   .b_in        (b_in),
   .a_chain_in  (a_chain_in),
   .b_chain_in  (b_chain_in),
   .a_chain_out (a_chain_out),
   .b_chain_out (b_chain_out),
   .product     (product)
);

// File: tb/cfg_mult_cell_tb_top.sv
`timescale 1ns/1ps
module cfg_mult_cell_tb_top;

   localparam int NV = 512;

   logic       clk = 1'b0;
   logic       ce = 1'b1;
   logic       srst = 1'b1;
   logic [3:0] a_in = '0, b_in = '0, a_ch = '0, b_ch = '0;
   logic       sgn = 1'b0;

   logic [3:0] aco_i, bco_i, aco_m, bco_m, aco_c, bco_c;
   logic [7:0] p_i, p_m, p_c;

   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [7:0] exp_i [NV];
   logic [7:0] exp_m [NV];
   logic [7:0] exp_c [NV];
   logic [3:0] xs [NV];
   logic [3:0] ys [NV];

   always #2.5 clk = ~clk;

   // latency 3, A from data port, B from cascade input
   cfg_mult_cell #(.A_W(4), .B_W(4), .IN_REG_EN(1), .PIPE_REG_EN(1), .OUT_REG_EN(1),
                   .A_SRC_CHAIN(0), .B_SRC_CHAIN(1)) dut_i (
      .clk(clk), .ce(ce), .srst(srst), .a_in(a_in), .b_in(b_in),
      .a_chain_in(a_ch), .b_chain_in(b_ch), .is_signed(sgn),
      .a_chain_out(aco_i), .b_chain_out(bco_i), .product(p_i));

   // latency 1 (multiplier stage only), A from cascade, B from data port
   cfg_mult_cell #(.A_W(4), .B_W(4), .IN_REG_EN(0), .PIPE_REG_EN(1), .OUT_REG_EN(0),
                   .A_SRC_CHAIN(1), .B_SRC_CHAIN(0)) dut_m (
      .clk(clk), .ce(ce), .srst(srst), .a_in(a_in), .b_in(b_in),
      .a_chain_in(a_ch), .b_chain_in(b_ch), .is_signed(sgn),
      .a_chain_out(aco_m), .b_chain_out(bco_m), .product(p_m));

   // latency 0, both from data ports
   cfg_mult_cell #(.A_W(4), .B_W(4), .IN_REG_EN(0), .PIPE_REG_EN(0), .OUT_REG_EN(0),
                   .A_SRC_CHAIN(0), .B_SRC_CHAIN(0)) dut_c (
      .clk(clk), .ce(ce), .srst(srst), .a_in(a_in), .b_in(b_in),
      .a_chain_in(a_ch), .b_chain_in(b_ch), .is_signed(sgn),
      .a_chain_out(aco_c), .b_chain_out(bco_c), .product(p_c));

   function automatic logic [7:0] ref_mul(input logic [3:0] a, input logic [3:0] b, input logic s);
      int ia;
      int ib;
      int pr;
      ia = int'(a);
      ib = int'(b);
      if (s && ia > 7) ia = ia - 16;
      if (s && ib > 7) ib = ib - 16;
      pr = ia * ib;
      return pr[7:0];
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
      nvec++;
      if (act !== expv) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic drive_vec(input int v);
      logic [3:0] x;
      logic [3:0] y;
      logic       s;
      s = v[0];
      x = 4'(v >> 1);
      y = 4'(v >> 5);
      a_in = x;
      b_ch = y;
      a_ch = x ^ 4'h5;
      b_in = ~y;
      sgn  = s;
   endtask

   initial begin
      for (int v = 0; v < NV; v++) begin
         logic [3:0] x;
         logic [3:0] y;
         logic       s;
         s = v[0];
         x = 4'(v >> 1);
         y = 4'(v >> 5);
         xs[v]    = x;
         ys[v]    = y;
         exp_i[v] = ref_mul(x, y, s);
         exp_m[v] = ref_mul(x ^ 4'h5, ~y, s);
         exp_c[v] = ref_mul(x, ~y, s);
      end

      // reset state
      repeat (4) @(negedge clk);
      chk("R5 reset p_i", p_i, 8'h00);
      chk("R5 reset p_m", p_m, 8'h00);
      chk("R5 reset chain a", {4'h0, aco_i}, 8'h00);
      chk("R5 reset chain b", {4'h0, bco_i}, 8'h00);
      srst = 1'b0;

      // streamed exhaustive sweep, one vector per cycle
      for (int c = 0; c < NV + 4; c++) begin
         @(negedge clk);
         if (c >= 3 && c - 3 < NV)
            chk("R1 R2 R3 R8 latency3", p_i, exp_i[c-3]);
         if (c >= 1 && c - 1 < NV) begin
            chk("R1 R3 R7 latency1", p_m, exp_m[c-1]);
            chk("R6 chain a", {4'h0, aco_i}, {4'h0, xs[c-1]});
            chk("R6 chain b", {4'h0, bco_i}, {4'h0, ys[c-1]});
         end
         if (c < NV) begin
            drive_vec(c);
            #1;
            chk("R2 R3 R7 latency0", p_c, exp_c[c]);
            chk("R6 bypass chain a", {4'h0, aco_c}, {4'h0, a_in});
         end
      end

      // clock enable pause: 3 * -2 signed, 7 * 5 on the latency-1 cell
      @(negedge clk);
      a_in = 4'h3; b_ch = 4'he; sgn = 1'b1; a_ch = 4'h7; b_in = 4'h5;
      repeat (4) @(negedge clk);
      chk("R1 R2 settle p_i", p_i, 8'hfa);
      chk("R1 settle p_m", p_m, 8'h23);
      ce = 1'b0;
      for (int k = 0; k < 3; k++) begin
         a_in = 4'(k + 1); b_ch = 4'(k + 9); a_ch = 4'(k); b_in = 4'(k + 2); sgn = k[0];
         @(negedge clk);
         chk("R4 hold p_i", p_i, 8'hfa);
         chk("R4 hold p_m", p_m, 8'h23);
         chk("R4 hold chain b", {4'h0, bco_i}, 8'h0e);
      end

      // reset while enable is low
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      chk("R5 reset with ce low p_i", p_i, 8'h00);
      chk("R5 reset with ce low p_m", p_m, 8'h00);
      chk("R5 reset with ce low chain a", {4'h0, aco_i}, 8'h00);
      @(negedge clk);
      chk("R4 hold after reset p_i", p_i, 8'h00);

      // resume: 5 * 6 unsigned
      ce = 1'b1; a_in = 4'h5; b_ch = 4'h6; sgn = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 resume latency3", p_i, 8'h1e);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

endmodule